// File: doc/BRIEF.md
# Register Pair Increment Unit

This unit holds three 16-bit register pairs (BC, DE and HL) and an 8-bit flag register. It carries out the one-byte instruction that adds one to a register pair. A start strobe comes with the opcode byte. The unit checks whether the byte is one of the three increment opcodes. It then runs a fixed six-state sequence and writes the incremented value back to the chosen pair in the last state. In that same state it gives a one-clock done pulse, or an illegal-opcode pulse if the byte was not recognised.

The increment works on the whole 16-bit pair. A carry out of the low byte goes into the high byte, and the flag register is never changed by the instruction. A parallel load port and parallel read ports let surrounding logic set and observe the pairs and the flags. The load port works only while the sequencer is idle.

Top module: `pinc_unit`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, all three pairs and the flag register become zero, and the unit goes idle (`busy`, `done` and `illegal` low).
- R2: The opcode is decoded as bits [7:6] = 00, bits [3:0] = 0011 and bits [5:4] = pair index (00 = BC, 01 = DE, 10 = HL). So 0x03 increments BC, 0x13 increments DE and 0x23 increments HL. The other two pairs keep their values.
- R3: The increment covers all 16 bits, with the carry from the low byte going into the high byte. For example, 0x4050 becomes 0x4051 and 0x1FFF becomes 0x2000.
- R4: A pair holding 0xFFFF becomes 0x0000, and no carry indication appears on any port.
- R5: The flag register keeps its exact value across every instruction, whether the opcode is recognised or not.
- R6: A start that is accepted at a clock edge begins state 1. `busy` stays high for states 1 to 6, one clock each. `done` is high only during state 6. The chosen pair keeps its old value through state 6 and shows the new value after the edge that ends state 6, when `busy` falls.
- R7: Every opcode other than 0x03, 0x13 and 0x23 leaves all pairs and the flags unchanged. Such an opcode raises `illegal` for one clock in state 6 instead of `done`.
- R8: A start that arrives while `busy` is high is ignored: its opcode is neither latched nor executed.
- R9: `ld_sel` picks the load target (0 = BC, 1 = DE, 2 = HL, 3 = flags, taken from `ld_data[7:0]`). A load takes effect at the clock edge only while the unit is idle. A load attempt while `busy` is high changes nothing.
- R10: A reset during execution ends the instruction. No write-back happens and no done or illegal pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe; opcode is taken when idle |
| opcode | input | 8 | Instruction byte |
| ld_en | input | 1 | Parallel load enable |
| ld_sel | input | 2 | Load target: 0 BC, 1 DE, 2 HL, 3 flags |
| ld_data | input | 16 | Load value (flags use bits 7:0) |
| bc_q | output | 16 | Pair BC contents |
| de_q | output | 16 | Pair DE contents |
| hl_q | output | 16 | Pair HL contents |
| flags_q | output | 8 | Flag register contents |
| busy | output | 1 | High in states 1 to 6 |
| done | output | 1 | One-clock pulse in state 6 for a recognised opcode |
| illegal | output | 1 | One-clock pulse in state 6 for any other opcode |

## Verification
The bench builds the unit with its default parameters: 8-bit bytes and flags, an 8-bit opcode and six states. At this size all 256 opcode values can be swept, each against preloaded pair values and flags. All 256 high-byte values behind a 0xFF low byte can also be swept, which reaches every carry into the high byte and the 0xFFFF wrap. With only six states, the bench can also aim a late start, a load attempt and a reset at a chosen state in the middle of execution.

// File: rtl/pinc_pkg.sv
`timescale 1ns/1ps
package pinc_pkg;
  localparam int NUM_PAIRS = 3;

  typedef enum logic [1:0] {
    SEL_BC    = 2'd0,
    SEL_DE    = 2'd1,
    SEL_HL    = 2'd2,
    SEL_FLAGS = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pinc_decode.sv
`timescale 1ns/1ps
module pinc_decode #(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op,
  output logic            hit,
  output logic [1:0]      pair
);
  // Recognised form: top bits zero, pair index in bits 5:4, low nibble 0011.
  function automatic logic is_pair_inc(input logic [OP_W-1:0] o);
    logic upper_zero;
    upper_zero = (o[OP_W-1:6] == '0);
    return upper_zero && (o[3:0] == 4'b0011) && (o[5:4] != 2'b11);
  endfunction

  assign hit  = is_pair_inc(op);
  assign pair = op[5:4];
endmodule

// File: rtl/pinc_seq.sv
`timescale 1ns/1ps
module pinc_seq #(
  parameter int NUM_STATES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic last
);
  localparam int CNT_W = $clog2(NUM_STATES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_STATES);

  logic [CNT_W-1:0] cnt_q;

  assign busy   = (cnt_q != '0);
  assign last   = (cnt_q == LAST_CNT);
  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (accept) cnt_q <= CNT_W'(1);
    else if (last)   cnt_q <= '0;
    else if (busy)   cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/pinc_regs.sv
`timescale 1ns/1ps
module pinc_regs
  import pinc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FLAG_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_ok,
  input  logic [1:0]          ld_sel,
  input  logic [2*BYTE_W-1:0] ld_data,
  input  logic                wb_en,
  input  logic [1:0]          wb_pair,
  output logic [2*BYTE_W-1:0] pairs_q [NUM_PAIRS],
  output logic [FLAG_W-1:0]   flags_q
);
  localparam int PAIR_W = 2 * BYTE_W;

  // Two-byte increment: low byte first, its carry feeds the high byte.
  function automatic logic [PAIR_W-1:0] step_pair(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    logic [BYTE_W:0]   lo_sum;
    logic [BYTE_W-1:0] hi_sum;
    lo_sum = {1'b0, lo} + {{BYTE_W{1'b0}}, 1'b1};
    hi_sum = hi + {{(BYTE_W-1){1'b0}}, lo_sum[BYTE_W]};
    return {hi_sum, lo_sum[BYTE_W-1:0]};
  endfunction

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    logic [BYTE_W-1:0] hi_q, lo_q;
    logic              ld_hit, wb_hit;

    assign ld_hit = ld_ok && (ld_sel == 2'(g));
    assign wb_hit = wb_en && (wb_pair == 2'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (ld_hit) begin
        {hi_q, lo_q} <= ld_data;
      end else if (wb_hit) begin
        {hi_q, lo_q} <= step_pair(hi_q, lo_q);
      end
    end

    assign pairs_q[g] = {hi_q, lo_q};
  end

  always_ff @(posedge clk) begin
    if (rst)                                  flags_q <= '0;
    else if (ld_ok && ld_sel == SEL_FLAGS)    flags_q <= ld_data[FLAG_W-1:0];
  end
endmodule

// File: rtl/pinc_unit.sv
`timescale 1ns/1ps
module pinc_unit
  import pinc_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int FLAG_W     = 8,
  parameter int OP_W       = 8,
  parameter int NUM_STATES = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [OP_W-1:0]     opcode,
  input  logic                ld_en,
  input  logic [1:0]          ld_sel,
  input  logic [2*BYTE_W-1:0] ld_data,
  output logic [2*BYTE_W-1:0] bc_q,
  output logic [2*BYTE_W-1:0] de_q,
  output logic [2*BYTE_W-1:0] hl_q,
  output logic [FLAG_W-1:0]   flags_q,
  output logic                busy,
  output logic                done,
  output logic                illegal
);
  localparam int PAIR_W = 2 * BYTE_W;

  // Internal events, named for the checker.
  logic            seq_accept;
  logic            seq_last;
  logic            op_hit;
  logic [1:0]      op_pair;
  logic            ld_ok;
  logic [OP_W-1:0] op_q;
  logic [PAIR_W-1:0] pairs_q [NUM_PAIRS];

  pinc_seq #(.NUM_STATES(NUM_STATES)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .accept (seq_accept),
    .busy   (busy),
    .last   (seq_last)
  );

  always_ff @(posedge clk) begin
    if (rst)             op_q <= '0;
    else if (seq_accept) op_q <= opcode;
  end

  pinc_decode #(.OP_W(OP_W)) u_dec (
    .op   (op_q),
    .hit  (op_hit),
    .pair (op_pair)
  );

  assign done    = seq_last && op_hit;
  assign illegal = seq_last && !op_hit;
  assign ld_ok   = ld_en && !busy;

  pinc_regs #(.BYTE_W(BYTE_W), .FLAG_W(FLAG_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .ld_ok   (ld_ok),
    .ld_sel  (ld_sel),
    .ld_data (ld_data),
    .wb_en   (done),
    .wb_pair (op_pair),
    .pairs_q (pairs_q),
    .flags_q (flags_q)
  );

  assign bc_q = pairs_q[SEL_BC];
  assign de_q = pairs_q[SEL_DE];
  assign hl_q = pairs_q[SEL_HL];
endmodule

// File: rtl/pinc_unit_chk.sv
`timescale 1ns/1ps
module pinc_unit_chk #(
  parameter int PAIR_W = 16,
  parameter int FLAG_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic              seq_last,
  input logic [PAIR_W-1:0] bc_q,
  input logic [PAIR_W-1:0] de_q,
  input logic [PAIR_W-1:0] hl_q,
  input logic [FLAG_W-1:0] flags_q
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_illegal_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && illegal));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !seq_last) |=> busy);

  // R6
  idle_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    seq_last |=> !busy);

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (flags_q == $past(flags_q)));

  // R9
  no_load_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !seq_last) |=> ($stable(bc_q) && $stable(de_q) && $stable(hl_q)));

  // R7
  illegal_noop_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> ($stable(bc_q) && $stable(de_q) && $stable(hl_q)));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (PAIR_W'((bc_q - $past(bc_q)) + (de_q - $past(de_q)) + (hl_q - $past(hl_q)))
              == PAIR_W'(1)));
endmodule

bind pinc_unit pinc_unit_chk #(.PAIR_W(PAIR_W), .FLAG_W(FLAG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .illegal  (illegal),
  .seq_last (seq_last),
  .bc_q     (bc_q),
  .de_q     (de_q),
  .hl_q     (hl_q),
  .flags_q  (flags_q)
);

// File: tb/pinc_unit_tb.sv
`timescale 1ns/1ps
module pinc_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] bc_q, de_q, hl_q;
  logic [7:0]  flags_q;
  logic        busy, done, illegal;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pinc_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .bc_q(bc_q), .de_q(de_q), .hl_q(hl_q), .flags_q(flags_q),
    .busy(busy), .done(done), .illegal(illegal)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int plus_one(int v);
    return (v + 1) % 65536;
  endfunction

  task automatic load(int sel, int val);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 2'(sel); ld_data = 16'(val);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Issue one instruction and check timing and outcome.
  task automatic run_op(int op, string tag);
    int b0, d0, h0, f0, eb, ed, eh;
    bit hit;
    b0 = bc_q; d0 = de_q; h0 = hl_q; f0 = flags_q;
    hit = (op / 64 == 0) && (op % 16 == 3) && (((op / 16) % 4) != 3);
    eb = b0; ed = d0; eh = h0;
    if (hit && (op / 16) % 4 == 0) eb = plus_one(b0);
    if (hit && (op / 16) % 4 == 1) ed = plus_one(d0);
    if (hit && (op / 16) % 4 == 2) eh = plus_one(h0);
    @(negedge clk);
    start = 1'b1; opcode = 8'(op);
    @(negedge clk);                 // state 1
    start = 1'b0;
    check({tag, " R6 busy in state 1"}, busy, 1);
    repeat (5) @(negedge clk);      // state 6
    check({tag, " R6/R2 done in state 6"}, done, hit);
    check({tag, " R7 illegal in state 6"}, illegal, !hit);
    check({tag, " R6 old value held"}, bc_q + de_q + hl_q, b0 + d0 + h0);
    @(negedge clk);                 // idle again
    check({tag, " R6 busy cleared"}, busy, 0);
    check({tag, " R6 done one clock"}, done, 0);
    check({tag, " R2/R3 BC"}, bc_q, eb);
    check({tag, " R2/R3 DE"}, de_q, ed);
    check({tag, " R2/R3 HL"}, hl_q, eh);
    check({tag, " R5 flags"}, flags_q, f0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int vals[8] = '{16'h4050, 16'h1FFF, 16'hFFFF, 16'h00FF,
                    16'h7FFF, 16'h0000, 16'h12FE, 16'hABFF};
    // R1 reset state, with loads attempted under reset
    ld_en = 1'b1; ld_sel = 2'd0; ld_data = 16'h1234;
    repeat (3) @(negedge clk);
    ld_en = 1'b0; rst = 1'b0;
    check("R1 BC", bc_q, 0); check("R1 DE", de_q, 0);
    check("R1 HL", hl_q, 0); check("R1 flags", flags_q, 0);
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    check("R1 illegal", illegal, 0);

    // R9 load and read back
    load(0, 16'h4050); load(1, 16'h1FFF); load(2, 16'hFFFF); load(3, 16'hA5D5);
    check("R9 BC load", bc_q, 16'h4050); check("R9 DE load", de_q, 16'h1FFF);
    check("R9 HL load", hl_q, 16'hFFFF); check("R9 flags load", flags_q, 16'hD5);

    // R3/R4 worked cases
    run_op(8'h03, "R3 0x4050");
    check("R3 BC 0x4051", bc_q, 16'h4051);
    run_op(8'h13, "R3 0x1FFF");
    check("R3 DE 0x2000", de_q, 16'h2000);
    run_op(8'h23, "R4 wrap");
    check("R4 HL 0x0000", hl_q, 0);

    // R2/R5/R7 sweep of every opcode
    for (int op = 0; op < 256; op++) begin
      load(0, vals[op % 8]);
      load(1, vals[(op + 3) % 8]);
      load(2, vals[(op + 5) % 8]);
      load(3, op ^ 8'h5A);
      run_op(op, $sformatf("R7 sweep op=%02h", op));
    end

    // R3/R4 every high byte behind a 0xFF low byte
    for (int k = 0; k < 256; k++) begin
      load(2, k * 256 + 255);
      run_op(8'h23, $sformatf("R3 carry k=%0d", k));
      check("R3/R4 carry into high byte", hl_q, ((k + 1) % 256) * 256);
    end

    // R8 start while busy is ignored
    load(0, 16'h0010); load(1, 16'h3333);
    @(negedge clk); start = 1'b1; opcode = 8'h03;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; opcode = 8'h13;   // state 2
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);                       // idle after state 6
    check("R8 busy cleared", busy, 0);
    check("R8 BC once", bc_q, 16'h0011);
    repeat (7) @(negedge clk);
    check("R8 DE untouched", de_q, 16'h3333);
    check("R8 no second run", busy, 0);

    // R9 load during busy is ignored
    load(3, 16'h0042);
    @(negedge clk); start = 1'b1; opcode = 8'h03;
    @(negedge clk); start = 1'b0;
    ld_en = 1'b1; ld_sel = 2'd0; ld_data = 16'hAAAA;
    @(negedge clk); ld_sel = 2'd3; ld_data = 16'h00FF;
    @(negedge clk); ld_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 BC not loaded while busy", bc_q, 16'h0012);
    check("R9 flags not loaded while busy", flags_q, 16'h42);

    // R10 reset during execution
    load(1, 16'h0700);
    @(negedge clk); start = 1'b1; opcode = 8'h13;
    @(negedge clk); start = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 busy after reset", busy, 0);
    check("R10 DE cleared", de_q, 0);
    repeat (6) begin
      @(negedge clk);
      check("R10 no done after reset", done | illegal, 0);
    end
    check("R10 DE still zero", de_q, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule